// File: doc/BRIEF.md
# Dead-Battery Allowance Supervisor

This block sits after a USB charger-detection sequencer. When detection finishes, it takes the port class that was found and starts a long supervision window. A nominal 30-minute window is allowed, and the window can never be set past 45 minutes. During the window a device whose battery is flat may draw a small current, provided it forces a voltage source onto D+ and keeps its data path isolated. A filtered battery-good input decides, cycle by cycle, whether the data isolation switch is closed and whether the D+ source is driven.

The block also produces the final charger-detected, charge-allowed and switch-open status outputs. The window keeps running while the battery-good input toggles. If the window ends while the battery is still flat, the block enters a fault state. In that state all status outputs are released. Only a loss of bus-valid clears the fault. The window length is built from a per-minute prescaler and a minute counter, and both are parameters.

Top module: `dbp_timer_ctrl`

## Requirements
- R1: The supervision window ends exactly PRESCALE*MINUTES clock cycles after the edge that accepts detection done. MINUTES must lie between 1 and MAX_MINUTES (45), and this is checked at elaboration.
- R2: Reset, a low bus_valid_i, and the time before detection done is accepted all give the idle outputs: sw_open_o=1, dp_src_en_o=0, chg_det_o=0, chg_allow_o=0. A low bus_valid_i returns the block to idle on the next edge, and det_done_i has no effect while bus_valid_i is low.
- R3: For a standard port (port_kind_i=0) or a charging downstream port (port_kind_i=1) with the battery good, the switch is closed (sw_open_o=0), dp_src_en_o=0 and chg_allow_o=1. chg_det_o is 1 only for the charging downstream port.
- R4: For port kinds 0, 1 and 3 with the battery flat during the window, sw_open_o=1 and dp_src_en_o=1, with chg_allow_o=1.
- R5: For a dedicated charger (port_kind_i=2), sw_open_o=1, chg_det_o=1 and chg_allow_o=1. dp_src_en_o=1 throughout the window whatever the battery state. After the window, dp_src_en_o follows the filtered battery-good level.
- R6: Changes of battery-good during the window never restart or stretch it. The window still ends at the cycle given by R1.
- R7: If the filtered battery-good is low when the window ends, the block enters a fault state with sw_open_o=1, dp_src_en_o=0, chg_det_o=0 and chg_allow_o=0, for every port kind.
- R8: The fault persists while bus_valid_i stays high, whatever det_done_i and bat_good_i do. A new window needs bus_valid_i low for at least one edge, followed by detection done.
- R9: If the battery is good when the window ends, no fault is raised. chg_allow_o stays 1, and the switch still follows battery-good (kinds 0, 1 and 3), with dp_src_en_o=0 for those kinds.
- R10: bat_good_i passes through SYNC_STAGES flops and a DEBOUNCE_CYC filter. Outputs react on the (SYNC_STAGES+DEBOUNCE_CYC)-th edge after a change. Elaboration rejects settings whose response exceeds 30 ms at CLK_KHZ.
- R11: The port kind is captured on the edge that accepts detection done. Code 3 is treated as a standard port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid_i | input | 1 | Bus supply above its valid threshold |
| det_done_i | input | 1 | Detection sequencer has finished |
| port_kind_i | input | 2 | Port class: 0 standard, 1 charging downstream, 2 dedicated, 3 treated as standard |
| bat_good_i | input | 1 | Asynchronous battery-good level |
| sw_open_o | output | 1 | 1 = data isolation switch open |
| dp_src_en_o | output | 1 | 1 = force the D+ voltage source |
| chg_det_o | output | 1 | 1 = charging port detected |
| chg_allow_o | output | 1 | 1 = charge may be drawn from the bus |

## Verification
The status outputs decode the state registers directly, so a change of bus_valid_i or det_done_i shows on the outputs one edge later. The window-end change shows exactly PRESCALE*MINUTES edges after the accepting edge. A battery-good change needs SYNC_STAGES+DEBOUNCE_CYC edges to reach the outputs. Stimulus is applied on falling edges, and each result is sampled on the falling edge one cycle before its due edge and again on the falling edge just after it. Each latency is therefore pinned to a single edge, not merely bounded.

// File: rtl/dbp_pkg.sv
package dbp_pkg;

   typedef enum logic [1:0] {
      PK_STD = 2'd0,
      PK_CDN = 2'd1,
      PK_DED = 2'd2,
      PK_RSV = 2'd3
   } port_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RUN   = 2'd1,
      ST_DONE  = 2'd2,
      ST_FAULT = 2'd3
   } sup_state_e;

endpackage

// File: rtl/dbp_bat_filter.sv
module dbp_bat_filter #(
   parameter int SYNC_STAGES  = 2,
   parameter int DEBOUNCE_CYC = 500000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic good_o
);
   localparam int CW = $clog2(DEBOUNCE_CYC + 1);
   localparam logic [CW-1:0] CNT_LAST = CW'(DEBOUNCE_CYC - 1);

   logic [SYNC_STAGES-1:0] sh_q;
   logic [CW-1:0]          cnt_q;
   logic                   good_q;
   logic                   synced;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[SYNC_STAGES-2:0], raw_i};
   end

   assign synced = sh_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         good_q <= 1'b0;
      end else if (synced == good_q) begin
         cnt_q <= '0;
      end else if (cnt_q == CNT_LAST) begin
         good_q <= synced;
         cnt_q  <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign good_o = good_q;

   // R10: the filtered level only moves after a full run of disagreeing samples
   assert_full_debounce_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(good_q) |-> $past(cnt_q) == CNT_LAST);

endmodule

// File: rtl/dbp_min_timer.sv
module dbp_min_timer #(
   parameter longint unsigned PRESCALE = 64'd3000000000,
   parameter int              MINUTES  = 30
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic expire_o
);
   localparam int MW = $clog2(MINUTES + 1);
   localparam logic [MW-1:0] MIN_LAST = MW'(MINUTES - 1);

   logic          tick;
   logic [MW-1:0] min_q;

   generate
      if (PRESCALE == 64'd1) begin : g_no_pre
         assign tick = 1'b1;
      end else begin : g_pre
         localparam int PW = $clog2(PRESCALE);
         localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 64'd1);
         logic [PW-1:0] pre_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              pre_q <= '0;
            else if (!run_i)         pre_q <= '0;
            else if (pre_q == PRE_LAST) pre_q <= '0;
            else                     pre_q <= pre_q + 1'b1;
         end

         assign tick = (pre_q == PRE_LAST);

         // R1: prescaler starts from zero whenever a window begins
         assert_pre_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
            !run_i |=> pre_q == '0);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 min_q <= '0;
      else if (!run_i)            min_q <= '0;
      else if (tick)              min_q <= (min_q == MIN_LAST) ? '0 : min_q + 1'b1;
   end

   assign expire_o = run_i && tick && (min_q == MIN_LAST);

   // R1: minute counter stays inside the configured window
   assert_min_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
      min_q <= MIN_LAST);

endmodule

// File: rtl/dbp_timer_ctrl.sv
module dbp_timer_ctrl
   import dbp_pkg::*;
#(
   parameter int              CLK_KHZ      = 50000,
   parameter longint unsigned PRESCALE     = 64'd3000000000,
   parameter int              MINUTES      = 30,
   parameter int              MAX_MINUTES  = 45,
   parameter int              SYNC_STAGES  = 2,
   parameter int              DEBOUNCE_CYC = 500000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_valid_i,
   input  logic       det_done_i,
   input  logic [1:0] port_kind_i,
   input  logic       bat_good_i,
   output logic       sw_open_o,
   output logic       dp_src_en_o,
   output logic       chg_det_o,
   output logic       chg_allow_o
);
   localparam longint RESP_CYC  = longint'(SYNC_STAGES + DEBOUNCE_CYC);
   localparam longint LIMIT_CYC = longint'(CLK_KHZ) * 30;

   generate
      if (MINUTES < 1 || MINUTES > MAX_MINUTES) begin : g_bad_minutes
         $error("window length outside the allowed minute range");
      end
      if (MAX_MINUTES > 45) begin : g_bad_ceiling
         $error("minute ceiling above 45");
      end
      if (SYNC_STAGES < 2 || DEBOUNCE_CYC < 1) begin : g_bad_filter
         $error("battery filter needs two sync flops and a nonzero debounce");
      end
      if (RESP_CYC > LIMIT_CYC) begin : g_slow_filter
         $error("battery filter response exceeds 30 ms");
      end
   endgenerate

   sup_state_e st_q;
   port_kind_e kind_q;
   logic       bat_ok;
   logic       timer_exp;
   logic       is_charger;

   dbp_bat_filter #(
      .SYNC_STAGES  (SYNC_STAGES),
      .DEBOUNCE_CYC (DEBOUNCE_CYC)
   ) i_filter (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (bat_good_i),
      .good_o (bat_ok)
   );

   dbp_min_timer #(
      .PRESCALE (PRESCALE),
      .MINUTES  (MINUTES)
   ) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_i    (st_q == ST_RUN),
      .expire_o (timer_exp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         kind_q <= PK_STD;
      end else if (!bus_valid_i) begin
         st_q <= ST_IDLE;
      end else begin
         unique case (st_q)
            ST_IDLE: if (det_done_i) begin
               st_q   <= ST_RUN;
               kind_q <= port_kind_e'(port_kind_i);
            end
            ST_RUN: if (timer_exp) st_q <= bat_ok ? ST_DONE : ST_FAULT;
            default: st_q <= st_q;
         endcase
      end
   end

   assign is_charger = (kind_q == PK_CDN) || (kind_q == PK_DED);

   always_comb begin
      sw_open_o   = 1'b1;
      dp_src_en_o = 1'b0;
      chg_det_o   = 1'b0;
      chg_allow_o = 1'b0;
      unique case (st_q)
         ST_RUN: begin
            chg_allow_o = 1'b1;
            chg_det_o   = is_charger;
            if (kind_q == PK_DED) begin
               dp_src_en_o = 1'b1;
            end else begin
               sw_open_o   = !bat_ok;
               dp_src_en_o = !bat_ok;
            end
         end
         ST_DONE: begin
            chg_allow_o = 1'b1;
            chg_det_o   = is_charger;
            if (kind_q == PK_DED) dp_src_en_o = bat_ok;
            else                  sw_open_o   = !bat_ok;
         end
         default: ;
      endcase
   end

   // R8: fault is left only through a bus drop
   assert_fault_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_FAULT && bus_valid_i) |=> st_q == ST_FAULT);

   // R2: a bus drop releases every status output on the next edge
   assert_bus_drop_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_valid_i |=> (sw_open_o && !dp_src_en_o && !chg_det_o && !chg_allow_o));

   // R7: a window ending on a flat battery lands in the fault state
   assert_flat_expiry_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (timer_exp && bus_valid_i && !bat_ok) |=> (st_q == ST_FAULT && !chg_allow_o));

endmodule

// File: tb/test_dbp_timer_ctrl.sv
module test_dbp_timer_ctrl;
   localparam longint unsigned PRE = 64'd4;
   localparam int MIN     = 3;
   localparam int DEB     = 3;
   localparam int SYN     = 2;
   localparam int RUN_LEN = 12;
   localparam int LAT     = SYN + DEB;

   localparam logic [3:0] IDLE_O = 4'b1000;

   // {kind[1:0], battery, expected {sw_open, dp_src, chg_det, chg_allow}}
   localparam logic [6:0] VEC [8] = '{
      {2'd0, 1'b1, 4'b0001},
      {2'd0, 1'b0, 4'b1101},
      {2'd1, 1'b1, 4'b0011},
      {2'd1, 1'b0, 4'b1111},
      {2'd2, 1'b1, 4'b1111},
      {2'd2, 1'b0, 4'b1111},
      {2'd3, 1'b1, 4'b0001},
      {2'd3, 1'b0, 4'b1101}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus = 1'b0;
   logic       det = 1'b0;
   logic       bat = 1'b0;
   logic [1:0] kind = 2'd0;
   logic       sw_open, dp_src, chg_det, chg_allow;
   int         total = 0;
   int         bad = 0;
   bit         finished = 1'b0;

   always #10 clk = ~clk;

   dbp_timer_ctrl #(
      .PRESCALE     (PRE),
      .MINUTES      (MIN),
      .SYNC_STAGES  (SYN),
      .DEBOUNCE_CYC (DEB)
   ) i_dbp_timer_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_valid_i (bus),
      .det_done_i  (det),
      .port_kind_i (kind),
      .bat_good_i  (bat),
      .sw_open_o   (sw_open),
      .dp_src_en_o (dp_src),
      .chg_det_o   (chg_det),
      .chg_allow_o (chg_allow)
   );

   task automatic tick(int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(string tag, logic [3:0] exp);
      logic [3:0] got;
      got = {sw_open, dp_src, chg_det, chg_allow};
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %b expected %b", tag, got, exp);
      end
   endtask

   task automatic set_bat(logic v);
      bat = v;
      tick(LAT);
   endtask

   task automatic start_det(logic [1:0] k);
      kind = k;
      bus  = 1'b1;
      det  = 1'b1;
      tick(1);
      det  = 1'b0;
   endtask

   task automatic unplug();
      bus = 1'b0;
      tick(1);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         bad++;
         total++;
         $display("FAIL watchdog: got hung expected completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      tick(2);
      chk("R2 reset state", IDLE_O);
      rst_n = 1'b1;
      tick(1);
      bus = 1'b1;
      tick(3);
      chk("R2 bus valid before detection", IDLE_O);
      bus = 1'b0;
      det = 1'b1;
      tick(2);
      chk("R2 detection ignored without bus", IDLE_O);
      det = 1'b0;

      // table walk: R3 R4 R5 R11
      for (int i = 0; i < 8; i++) begin
         set_bat(VEC[i][4]);
         start_det(VEC[i][6:5]);
         chk($sformatf("R3 R4 R5 R11 vector %0d", i), VEC[i][3:0]);
         unplug();
         chk($sformatf("R2 idle after vector %0d", i), IDLE_O);
      end

      // R1 and R7: exact window length, flat battery
      set_bat(1'b0);
      start_det(2'd1);
      tick(RUN_LEN - 1);
      chk("R1 window still open one edge early", 4'b1111);
      tick(1);
      chk("R7 fault at window end", IDLE_O);
      // R8: fault ignores detection and battery
      det = 1'b1;
      tick(2);
      det = 1'b0;
      chk("R8 fault ignores detection done", IDLE_O);
      bat = 1'b1;
      tick(LAT + 1);
      chk("R8 fault ignores good battery", IDLE_O);
      unplug();
      start_det(2'd2);
      chk("R8 new window after bus drop", 4'b1111);
      unplug();

      // R7 for a dedicated charger
      set_bat(1'b0);
      start_det(2'd2);
      tick(RUN_LEN);
      chk("R7 dedicated charger faults on flat battery", IDLE_O);
      unplug();

      // R6 and R10: battery toggles inside the window
      set_bat(1'b0);
      start_det(2'd0);
      bat = 1'b1;
      tick(LAT - 1);
      chk("R10 switch still open before filter delay", 4'b1101);
      tick(1);
      chk("R10 switch closed at filter delay", 4'b0001);
      bat = 1'b0;
      tick(LAT - 1);
      chk("R10 switch still closed before filter delay", 4'b0001);
      tick(1);
      chk("R4 switch reopened on flat battery", 4'b1101);
      tick(1);
      chk("R6 window not restarted by toggling", 4'b1101);
      tick(1);
      chk("R6 window ends on original schedule", IDLE_O);
      unplug();

      // R9: good battery at window end
      set_bat(1'b1);
      start_det(2'd0);
      tick(RUN_LEN);
      chk("R9 no fault with good battery", 4'b0001);
      bat = 1'b0;
      tick(LAT);
      chk("R9 switch opens after window, source off", 4'b1001);
      unplug();

      // R5: dedicated charger after window
      set_bat(1'b1);
      start_det(2'd2);
      tick(RUN_LEN);
      chk("R5 dedicated source held with good battery", 4'b1111);
      bat = 1'b0;
      tick(LAT);
      chk("R5 dedicated source dropped after window", 4'b1011);
      unplug();

      // R2: bus drop in the middle of a window
      set_bat(1'b1);
      start_det(2'd1);
      tick(3);
      bus = 1'b0;
      tick(1);
      chk("R2 bus drop mid window", IDLE_O);

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule